// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sets the rhythm of the clock line for an I2C master. It drives SCL low for a programmed number of system clocks, releases it, waits until the line actually reads back high, and then holds it high for a programmed count plus a fixed overhead. Two count pairs are held at the inputs, one for standard mode and one for fast mode. A speed-select input picks which pair is used. Count values below a safe floor are raised to that floor.

Two single-cycle ticks tell the data path when to act. The first tick marks where SDA may change. It comes a programmable number of clocks after SCL is pulled low. The second tick marks where SDA should be sampled. It comes in the first counted high cycle, after any stretching by a slave has ended.

All settings are captured only while the block is idle. Once a run request starts the clock, changes on the setting inputs have no effect until the block is idle again. When the run request is dropped, the current period is finished and SCL is left released.

Top module: `scl_tgen`

## Requirements
- R1: During reset and while idle, scl_o is 1 (line released) and both ticks are 0.
- R2: With fast_i = 1 captured at start, the fast-mode high and low counts set the period; with fast_i = 0, the standard-mode counts do.
- R3: Every low phase lasts exactly the selected low count plus 1 clock. The count starts in the first cycle in which scl_o is 0.
- R4: With no stretching, every high phase lasts the selected high count plus 8 clocks. It is measured from the first cycle with scl_o = 1.
- R5: High counting starts only once scl_i reads 1. Each cycle that scl_i stays 0 after release adds one cycle to the high phase. sda_sample_o pulses in the first counted high cycle, which is index s+1 of the high phase for s stretch cycles (index 0 is the release cycle).
- R6: Counts, hold and speed select are captured from the inputs only while idle. Changes made while running do not alter the period or the tick positions.
- R7: A high count below 6 acts as 6. A low count below 8 acts as 8.
- R8: sda_change_o pulses at index H of the low phase, where index 0 is the first low cycle. H is the hold value, limited to the effective low count.
- R9: The first low cycle begins in the cycle after run_i is first seen high while idle. When run_i is 0 at the end of a high phase, the block returns to idle and keeps SCL released.
- R10: Each period holds exactly one sda_change_o pulse and one sda_sample_o pulse, and the two never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run request; 1 keeps SCL toggling |
| fast_i | input | 1 | Speed select: 1 fast pair, 0 standard pair |
| ss_hcnt_i | input | CNT_W | Standard-mode high count |
| ss_lcnt_i | input | CNT_W | Standard-mode low count |
| fs_hcnt_i | input | CNT_W | Fast-mode high count |
| fs_lcnt_i | input | CNT_W | Fast-mode low count |
| sda_hold_i | input | HOLD_W | SDA hold in clocks after SCL goes low |
| scl_i | input | 1 | Synchronised SCL line read-back |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_change_o | output | 1 | Tick: SDA may change |
| sda_sample_o | output | 1 | Tick: SDA may be sampled |

## Verification
The assertions assume that scl_i is already synchronised to clk_i and that it reads 0 whenever scl_o drives 0, as it does on a wired-AND line. They also assume that once SCL has risen, nothing else pulls it low before the block does. In the bench, scl_i is a loopback of scl_o held low for a chosen number of cycles after each release, which is how a stretching slave is modelled. The bench never lowers scl_i while the counted high phase is running. Setting changes are applied freely during runs, because the design is meant to ignore them there.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_REL  = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  localparam int unsigned HIGH_FLOOR    = 6;
  localparam int unsigned LOW_FLOOR     = 8;
  localparam int unsigned HIGH_OVERHEAD = 8;
endpackage

// File: rtl/scl_tgen_floor.sv
module scl_tgen_floor #(
  parameter int          W     = 16,
  parameter int unsigned FLOOR = 6
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] FLOOR_V = W'(FLOOR);
  assign val_o = (val_i < FLOOR_V) ? FLOOR_V : val_i;
endmodule

// File: rtl/scl_tgen_cfg.sv
module scl_tgen_cfg
  import scl_tgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              fast_i,
  input  logic [CNT_W-1:0]  ss_hcnt_i,
  input  logic [CNT_W-1:0]  ss_lcnt_i,
  input  logic [CNT_W-1:0]  fs_hcnt_i,
  input  logic [CNT_W-1:0]  fs_lcnt_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic [CNT_W-1:0]  hcnt_o,
  output logic [CNT_W-1:0]  lcnt_o,
  output logic [CNT_W-1:0]  hold_o
);
  // index 0: high count, index 1: low count
  logic [CNT_W-1:0] pick    [2];
  logic [CNT_W-1:0] floored [2];
  logic [CNT_W-1:0] hold_ext, hold_lim;

  assign pick[0] = fast_i ? fs_hcnt_i : ss_hcnt_i;
  assign pick[1] = fast_i ? fs_lcnt_i : ss_lcnt_i;

  for (genvar g = 0; g < 2; g++) begin : g_floor
    scl_tgen_floor #(
      .W    (CNT_W),
      .FLOOR((g == 0) ? HIGH_FLOOR : LOW_FLOOR)
    ) u_floor (
      .val_i(pick[g]),
      .val_o(floored[g])
    );
  end

  assign hold_ext = CNT_W'(hold_i);
  // hold beyond the low phase lands on its last cycle
  assign hold_lim = (hold_ext > floored[1]) ? floored[1] : hold_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= CNT_W'(HIGH_FLOOR);
      lcnt_o <= CNT_W'(LOW_FLOOR);
      hold_o <= '0;
    end else if (load_i) begin
      hcnt_o <= floored[0];
      lcnt_o <= floored[1];
      hold_o <= hold_lim;
    end
  end
endmodule

// File: rtl/scl_tgen_fsm.sv
module scl_tgen_fsm
  import scl_tgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] hcnt_i,
  input  logic [CNT_W-1:0] lcnt_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             scl_o,
  output logic             change_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             load_o
);
  localparam int CW = CNT_W + 1;
  // release cycle adds 1, counted high of tail k lasts k+1
  localparam logic [CW-1:0] HIGH_TAIL = CW'(HIGH_OVERHEAD - 2);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          low_end, high_end;

  assign low_end  = (cnt == {1'b0, lcnt_i});
  assign high_end = (cnt == ({1'b0, hcnt_i} + HIGH_TAIL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          cnt <= '0;
          if (run_i) ph <= PH_LOW;
        end
        PH_LOW: begin
          if (low_end) begin
            ph  <= PH_REL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_REL: begin
          cnt <= '0;
          if (scl_i) ph <= PH_HIGH;
        end
        PH_HIGH: begin
          if (high_end) begin
            ph  <= run_i ? PH_LOW : PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign scl_o    = (ph != PH_LOW);
  assign change_o = (ph == PH_LOW) && (cnt == {1'b0, hold_i});
  assign sample_o = (ph == PH_HIGH) && (cnt == '0);
  assign busy_o   = (ph != PH_IDLE);
  assign load_o   = (ph == PH_IDLE);
endmodule

// File: rtl/scl_tgen.sv
module scl_tgen #(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              fast_i,
  input  logic [CNT_W-1:0]  ss_hcnt_i,
  input  logic [CNT_W-1:0]  ss_lcnt_i,
  input  logic [CNT_W-1:0]  fs_hcnt_i,
  input  logic [CNT_W-1:0]  fs_lcnt_i,
  input  logic [HOLD_W-1:0] sda_hold_i,
  input  logic              scl_i,
  output logic              scl_o,
  output logic              sda_change_o,
  output logic              sda_sample_o
);
  logic [CNT_W-1:0] cur_hcnt, cur_lcnt, cur_hold;
  logic             busy, load;

  scl_tgen_cfg #(
    .CNT_W (CNT_W),
    .HOLD_W(HOLD_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .fast_i   (fast_i),
    .ss_hcnt_i(ss_hcnt_i),
    .ss_lcnt_i(ss_lcnt_i),
    .fs_hcnt_i(fs_hcnt_i),
    .fs_lcnt_i(fs_lcnt_i),
    .hold_i   (sda_hold_i),
    .hcnt_o   (cur_hcnt),
    .lcnt_o   (cur_lcnt),
    .hold_o   (cur_hold)
  );

  scl_tgen_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .scl_i   (scl_i),
    .hcnt_i  (cur_hcnt),
    .lcnt_i  (cur_lcnt),
    .hold_i  (cur_hold),
    .scl_o   (scl_o),
    .change_o(sda_change_o),
    .sample_o(sda_sample_o),
    .busy_o  (busy),
    .load_o  (load)
  );
endmodule

// File: rtl/scl_tgen_chk.sv
module scl_tgen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             scl_o,
  input logic             sda_change_i,
  input logic             sda_sample_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] hcnt_i,
  input logic [CNT_W-1:0] lcnt_i
);
  logic [31:0] low_run, high_run, stretch_run;
  logic        scl_q, seen_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run     <= '0;
      high_run    <= '0;
      stretch_run <= '0;
      scl_q       <= 1'b1;
      seen_rise   <= 1'b0;
    end else begin
      scl_q       <= scl_o;
      low_run     <= scl_o ? '0 : low_run + 1;
      high_run    <= scl_o ? high_run + 1 : '0;
      stretch_run <= !scl_o ? '0 : (!scl_i ? stretch_run + 1 : stretch_run);
      if (!busy_i)             seen_rise <= 1'b0;
      else if (scl_o && !scl_q) seen_rise <= 1'b1;
    end
  end

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (scl_o && !sda_change_i && !sda_sample_i));

  p_low_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && !scl_q) |-> (low_run == 32'(lcnt_i) + 32'd1));

  p_high_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_o && scl_q && seen_rise) |-> (high_run == 32'(hcnt_i) + 32'd8 + stretch_run));

  p_cfg_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(hcnt_i) && $stable(lcnt_i)));

  p_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (hcnt_i >= CNT_W'(6) && lcnt_i >= CNT_W'(8)));

  p_change_in_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_change_i |-> !scl_o);

  p_ticks_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sda_change_i, sda_sample_i}));

  p_sample_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_sample_i |-> (scl_o && scl_i));
endmodule

bind scl_tgen scl_tgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .scl_o       (scl_o),
  .sda_change_i(sda_change_o),
  .sda_sample_i(sda_sample_o),
  .busy_i      (busy),
  .hcnt_i      (cur_hcnt),
  .lcnt_i      (cur_lcnt)
);

// File: tb/scl_tgen_bench.sv
module scl_tgen_bench;
  localparam int CNT_W  = 16;
  localparam int HOLD_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              run = 1'b0;
  logic              fast = 1'b0;
  logic [CNT_W-1:0]  ss_h = '0, ss_l = '0, fs_h = '0, fs_l = '0;
  logic [HOLD_W-1:0] hold = '0;
  logic              scl_i, scl_o, chg, smp;
  int                stretch_len = 0;
  int                rel_cnt = 0;
  int                tests = 0, fails = 0;

  always #5 clk = ~clk;

  // slave model: keeps the line low stretch_len cycles after release
  always @(negedge clk) rel_cnt <= scl_o ? rel_cnt + 1 : 0;
  assign scl_i = scl_o && (rel_cnt > stretch_len);

  scl_tgen #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_scl_tgen (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .fast_i(fast),
    .ss_hcnt_i(ss_h), .ss_lcnt_i(ss_l), .fs_hcnt_i(fs_h), .fs_lcnt_i(fs_l),
    .sda_hold_i(hold), .scl_i(scl_i), .scl_o(scl_o),
    .sda_change_o(chg), .sda_sample_o(smp)
  );

  function automatic int eff_low(input int l);  return (l < 8) ? 8 : l; endfunction
  function automatic int eff_high(input int h); return (h < 6) ? 6 : h; endfunction
  function automatic int exp_chg(input int l, input int hd);
    return (hd > eff_low(l)) ? eff_low(l) : hd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // one period from the first low cycle; ends at next first low cycle
  task automatic measure(input int hlim, output int lc, output int hc,
                         output int ci, output int si, output int nc, output int ns);
    int guard = 0;
    while (scl_o !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    lc = 0; ci = -1; nc = 0;
    while (scl_o === 1'b0 && lc < 5000) begin
      if (chg) begin ci = lc; nc++; end
      lc++; @(negedge clk);
    end
    hc = 0; si = -1; ns = 0;
    while (scl_o === 1'b1 && hc < hlim) begin
      if (smp) begin si = hc; ns++; end
      if (chg) nc++;
      hc++; @(negedge clk);
    end
  endtask

  task automatic run_case(input string tag, input int sh, input int sl, input int fh,
                          input int fl, input int hd, input bit fs, input int st,
                          input int nper, input bit mutate);
    int lc, hc, ci, si, nc, ns, eh, el;
    ss_h = CNT_W'(sh); ss_l = CNT_W'(sl); fs_h = CNT_W'(fh); fs_l = CNT_W'(fl);
    hold = HOLD_W'(hd); fast = fs; stretch_len = st;
    eh = fs ? fh : sh; el = fs ? fl : sl;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk(scl_o === 1'b0, "R9 start low next cycle", int'(scl_o), 0);
    for (int p = 0; p < nper; p++) begin
      measure(5000, lc, hc, ci, si, nc, ns);
      chk(lc == eff_low(el) + 1, {tag, " low length"}, lc, eff_low(el) + 1);
      chk(hc == eff_high(eh) + 8 + st, {tag, " high length"}, hc, eff_high(eh) + 8 + st);
      chk(ci == exp_chg(el, hd), {tag, " change tick index"}, ci, exp_chg(el, hd));
      chk(si == st + 1, {tag, " sample tick index"}, si, st + 1);
      chk(nc == 1 && ns == 1, "R10 one tick each per period", nc * 10 + ns, 11);
      if (mutate && p == 0) begin
        ss_h = ss_h + 13; ss_l = ss_l + 11; fs_h = fs_h + 7; fs_l = fs_l + 9;
        hold = hold + 5; fast = ~fast;
      end
    end
    run = 1'b0;
    measure(300, lc, hc, ci, si, nc, ns);
    chk(lc == eff_low(el) + 1, "R9 last low completes", lc, eff_low(el) + 1);
    chk(hc == 300, "R9 stays released after stop", hc, 300);
    chk(si == st + 1, "R9 last sample tick", si, st + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      chk(scl_o === 1'b1 && !chg && !smp, "R1 reset released", int'(scl_o), 1);
    end
    rst_ni = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(scl_o === 1'b1 && !chg && !smp, "R1 idle released", int'(scl_o), 1);
    end
    run_case("R3 standard", 20, 30, 7, 9, 3, 1'b0, 0, 2, 1'b0);
    run_case("R2 fast",     40, 50, 7, 9, 2, 1'b1, 0, 2, 1'b0);
    run_case("R7 floor",    2, 3, 40, 40, 0, 1'b0, 0, 2, 1'b0);
    run_case("R8 hold cap", 12, 10, 30, 30, 50, 1'b0, 0, 2, 1'b0);
    run_case("R5 stretch",  9, 12, 30, 30, 4, 1'b0, 4, 2, 1'b0);
    run_case("R6 frozen",   15, 18, 25, 27, 6, 1'b0, 1, 3, 1'b1);
    run_case("R4 exact",    6, 8, 6, 8, 8, 1'b1, 0, 2, 1'b0);
    for (int i = 0; i < 20; i++) begin
      run_case("R3 random",
               int'($urandom_range(40)), int'($urandom_range(40)),
               int'($urandom_range(40)), int'($urandom_range(40)),
               int'($urandom_range(45)), 1'($urandom_range(1)),
               int'($urandom_range(5)), 2, 1'($urandom_range(1)));
    end
    summary();
    $finish;
  end
endmodule